// File: doc/BRIEF.md
# Probe Grid Observe/Control Sequencer

This block drives a grid of embedded test access points arranged as rows and columns inside a logic array. Each row has one probe line. When a probe line is raised, the node values of that row appear on a set of column sense lines shared by all rows. A set of column drivers lets the same paths push values back into the grid.

An observe command makes the block raise each probe line in turn and latch the sensed columns into a data register. Each latched row is folded into a multiple-input signature register. The finished signature then leaves on a single serial output. A write command raises one addressed probe line for one cycle and enables the column drivers under a mask, which forces the chosen storage elements to 0 or 1.

Commands use a start/done handshake. The surrounding test logic is expected to put the array into a known state before it starts an observe pass.

Top module: `probe_grid_seq`

## Requirements
- R1: After reset, all probe lines, all column drive enables, `tdo_valid` and `cmd_done` are low.
- R2: An observe command raises the probe lines one at a time, for one cycle each, from row 0 up to row ROWS-1. At most one probe line is ever high. No probe line is high while the block is idle.
- R3: The signature register is set to all ones when an observe command is accepted. For each row r in order, the update is sig = (sig << 1) ^ (sig[COLS-1] ? POLY : 0) ^ row_r, where POLY defaults to 8'h1D for eight columns.
- R4: After the last row has been folded in, the signature comes out on `tdo` least significant bit first, one bit per cycle. `tdo_valid` is high for exactly COLS consecutive cycles, and no probe line is high during that time.
- R5: `cmd_done` pulses high for exactly one cycle. It follows the last signature bit of an observe command and the drive cycle of a write command.
- R6: A write command raises only the probe line of `cmd_row` for one cycle. During that cycle `drive_en` equals `cmd_mask` and `drive_val` carries `cmd_data`. As a result, masked cells take the data value and unmasked cells keep their value.
- R7: A write command whose `cmd_row` is ROWS or above raises no probe line and enables no driver, and `cmd_done` still pulses.
- R8: A start received while a command is in progress is ignored. The running pass keeps its probe order and signature, no driver is enabled, and only one done pulse follows.
- R9: A start given in the cycle in which `cmd_done` is high is accepted as a new command.
- R10: Repeated observe passes over an unchanged grid return the same signature, because the seed is reloaded on each pass.
- R11: `drive_en` is zero outside the drive cycle of a write command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Command request, sampled while idle |
| cmd_write | input | 1 | 1 = write command, 0 = observe command |
| cmd_row | input | RW | Row address for a write command |
| cmd_mask | input | COLS | Column drive mask for a write command |
| cmd_data | input | COLS | Values to force for a write command |
| cmd_done | output | 1 | One-cycle completion pulse |
| probe_row | output | ROWS | Probe lines, one per row |
| sense_col | input | COLS | Column sense lines from the grid |
| drive_en | output | COLS | Column driver enables |
| drive_val | output | COLS | Column driver values |
| tdo | output | 1 | Serial signature output |
| tdo_valid | output | 1 | High while `tdo` carries a signature bit |

## Verification
The completion pulse and the acceptance of the next command can fall in the same cycle. The bench raises a write start in exactly the cycle in which an observe pass reports done. It then checks that, on the very next cycle, the write's probe line and drivers appear, with no idle gap and no second done pulse. A second overlap comes from a start injected in the middle of an observe scan. That start is judged by an unchanged probe order and signature, no driver activity, and a single done pulse.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SCAN  = 3'd1,
    ST_DRAIN = 3'd2,
    ST_SHIFT = 3'd3,
    ST_WRITE = 3'd4
  } pgs_state_e;
endpackage

// File: rtl/pgs_row_decode.sv
module pgs_row_decode #(
  parameter int ROWS = 6,
  parameter int RW   = 3
) (
  input  logic            en,
  input  logic [RW-1:0]   idx,
  output logic [ROWS-1:0] lines
);
  for (genvar g = 0; g < ROWS; g++) begin : g_line
    assign lines[g] = en && (idx == RW'(g));
  end
endmodule

// File: rtl/pgs_misr.sv
module pgs_misr #(
  parameter int              COLS = 8,
  parameter logic [COLS-1:0] POLY = 8'h1D
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            seed,
  input  logic            cap,
  input  logic            fold,
  input  logic            shift,
  input  logic [COLS-1:0] din,
  output logic            sig_lsb
);
  logic [COLS-1:0] dreg_q, dreg_n;
  logic [COLS-1:0] sig_q, sig_n;

  always_comb begin
    dreg_n = dreg_q;
    if (cap) dreg_n = din;
  end

  always_comb begin
    sig_n = sig_q;
    if (seed)
      sig_n = '1;
    else if (fold)
      sig_n = {sig_q[COLS-2:0], 1'b0} ^ (sig_q[COLS-1] ? POLY : '0) ^ dreg_q;
    else if (shift)
      sig_n = {1'b0, sig_q[COLS-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dreg_q <= '0;
      sig_q  <= '0;
    end else begin
      dreg_q <= dreg_n;
      sig_q  <= sig_n;
    end
  end

  assign sig_lsb = sig_q[0];

  a_r3_seed_ones: assert property (@(posedge clk) disable iff (!rst_n)
    seed |=> (sig_q == '1));
endmodule

// File: rtl/pgs_ctrl.sv
module pgs_ctrl
  import pgs_pkg::*;
#(
  parameter int ROWS = 6,
  parameter int COLS = 8,
  parameter int RW   = 3,
  parameter int CW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            wr_mode,
  input  logic [RW-1:0]   row,
  input  logic [COLS-1:0] mask,
  input  logic [COLS-1:0] data,
  output logic            probe_en,
  output logic [RW-1:0]   probe_idx,
  output logic [COLS-1:0] drv_en,
  output logic [COLS-1:0] drv_val,
  output logic            misr_seed,
  output logic            misr_cap,
  output logic            misr_fold,
  output logic            misr_shift,
  output logic            tdo_valid,
  output logic            done
);
  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(COLS - 1);

  pgs_state_e      st_q, st_n;
  logic [RW-1:0]   rcnt_q, rcnt_n;
  logic [CW-1:0]   bcnt_q, bcnt_n;
  logic [RW-1:0]   lrow_q;
  logic [COLS-1:0] lmask_q, ldata_q;
  logic            done_q, done_n;
  logic            accept, row_ok;

  assign accept = (st_q == ST_IDLE) && start;
  assign row_ok = (int'(lrow_q) < ROWS);

  always_comb begin
    st_n   = st_q;
    rcnt_n = rcnt_q;
    bcnt_n = bcnt_q;
    done_n = 1'b0;
    case (st_q)
      ST_IDLE: if (accept) begin
        st_n   = wr_mode ? ST_WRITE : ST_SCAN;
        rcnt_n = '0;
      end
      ST_SCAN: begin
        rcnt_n = rcnt_q + RW'(1);
        if (rcnt_q == LAST_ROW) st_n = ST_DRAIN;
      end
      ST_DRAIN: begin
        st_n   = ST_SHIFT;
        bcnt_n = '0;
      end
      ST_SHIFT: begin
        bcnt_n = bcnt_q + CW'(1);
        if (bcnt_q == LAST_BIT) begin
          st_n   = ST_IDLE;
          done_n = 1'b1;
        end
      end
      ST_WRITE: begin
        st_n   = ST_IDLE;
        done_n = 1'b1;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rcnt_q <= '0;
      bcnt_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      rcnt_q <= rcnt_n;
      bcnt_q <= bcnt_n;
      done_q <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lrow_q  <= '0;
      lmask_q <= '0;
      ldata_q <= '0;
    end else if (accept) begin
      lrow_q  <= row;
      lmask_q <= mask;
      ldata_q <= data;
    end
  end

  always_comb begin
    probe_en   = (st_q == ST_SCAN) || (st_q == ST_WRITE);
    probe_idx  = (st_q == ST_WRITE) ? lrow_q : rcnt_q;
    drv_en     = (st_q == ST_WRITE && row_ok) ? lmask_q : '0;
    drv_val    = (st_q == ST_WRITE) ? ldata_q : '0;
    misr_seed  = accept && !wr_mode;
    misr_cap   = (st_q == ST_SCAN);
    misr_fold  = (st_q == ST_SCAN && rcnt_q != '0) || (st_q == ST_DRAIN);
    misr_shift = (st_q == ST_SHIFT);
    tdo_valid  = (st_q == ST_SHIFT);
  end

  assign done = done_q;

  a_r2_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SCAN && rcnt_q != LAST_ROW) |=> (st_q == ST_SCAN && rcnt_q == $past(rcnt_q) + RW'(1)));
  a_r4_shift_run: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SHIFT && bcnt_q != LAST_BIT) |=> (st_q == ST_SHIFT));
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  a_r8_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SCAN && start) |=> (st_q == ST_SCAN || st_q == ST_DRAIN));
endmodule

// File: rtl/probe_grid_seq.sv
module probe_grid_seq #(
  parameter int              ROWS = 6,
  parameter int              COLS = 8,
  parameter logic [COLS-1:0] POLY = 8'h1D,
  localparam int             RW   = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int             CW   = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_start,
  input  logic            cmd_write,
  input  logic [RW-1:0]   cmd_row,
  input  logic [COLS-1:0] cmd_mask,
  input  logic [COLS-1:0] cmd_data,
  output logic            cmd_done,
  output logic [ROWS-1:0] probe_row,
  input  logic [COLS-1:0] sense_col,
  output logic [COLS-1:0] drive_en,
  output logic [COLS-1:0] drive_val,
  output logic            tdo,
  output logic            tdo_valid
);
  logic          probe_en;
  logic [RW-1:0] probe_idx;
  logic          m_seed, m_cap, m_fold, m_shift;

  pgs_ctrl #(.ROWS(ROWS), .COLS(COLS), .RW(RW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(cmd_start), .wr_mode(cmd_write),
    .row(cmd_row), .mask(cmd_mask), .data(cmd_data),
    .probe_en(probe_en), .probe_idx(probe_idx),
    .drv_en(drive_en), .drv_val(drive_val),
    .misr_seed(m_seed), .misr_cap(m_cap), .misr_fold(m_fold), .misr_shift(m_shift),
    .tdo_valid(tdo_valid), .done(cmd_done)
  );

  pgs_row_decode #(.ROWS(ROWS), .RW(RW)) u_dec (
    .en(probe_en), .idx(probe_idx), .lines(probe_row)
  );

  pgs_misr #(.COLS(COLS), .POLY(POLY)) u_misr (
    .clk(clk), .rst_n(rst_n), .seed(m_seed), .cap(m_cap), .fold(m_fold),
    .shift(m_shift), .din(sense_col), .sig_lsb(tdo)
  );

  a_r2_single_probe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(probe_row));
  a_r4_quiet_shift: assert property (@(posedge clk) disable iff (!rst_n)
    tdo_valid |-> (probe_row == '0));
  a_r11_drive_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en != '0) |-> $onehot(probe_row));
endmodule

// File: tb/test_probe_grid_seq.sv
`timescale 1ns/1ps
module test_probe_grid_seq;
  localparam int ROWS = 6;
  localparam int COLS = 8;
  localparam logic [COLS-1:0] POLY = 8'h1D;
  localparam int RW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_start, cmd_write, cmd_done, tdo, tdo_valid;
  logic [RW-1:0] cmd_row;
  logic [COLS-1:0] cmd_mask, cmd_data, sense_col, drive_en, drive_val;
  logic [ROWS-1:0] probe_row;
  logic [COLS-1:0] grid [ROWS];
  int n_chk = 0, n_bad = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  probe_grid_seq #(.ROWS(ROWS), .COLS(COLS), .POLY(POLY)) i_probe_grid_seq (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_write(cmd_write),
    .cmd_row(cmd_row), .cmd_mask(cmd_mask), .cmd_data(cmd_data), .cmd_done(cmd_done),
    .probe_row(probe_row), .sense_col(sense_col), .drive_en(drive_en),
    .drive_val(drive_val), .tdo(tdo), .tdo_valid(tdo_valid)
  );

  always_comb begin
    sense_col = '0;
    for (int r = 0; r < ROWS; r++) if (probe_row[r]) sense_col = sense_col | grid[r];
  end

  always @(posedge clk)
    for (int r = 0; r < ROWS; r++)
      if (probe_row[r])
        for (int c = 0; c < COLS; c++)
          if (drive_en[c]) grid[r][c] <= drive_val[c];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [COLS-1:0] exp_sig();
    logic [COLS-1:0] m = '1;
    for (int r = 0; r < ROWS; r++)
      m = {m[COLS-2:0], 1'b0} ^ (m[COLS-1] ? POLY : '0) ^ grid[r];
    return m;
  endfunction

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // Observe pass; inj >= 0 pulses a write start at that loop cycle. Returns in the done cycle.
  task automatic observe(input int inj, output logic [COLS-1:0] sig);
    int pidx = 0, nbits = 0, ndone = 0, cyc = 0;
    bit order_ok = 1, quiet = 1, probe_in_shift = 0;
    logic [COLS-1:0] exp = exp_sig();
    sig = '0;
    cmd_write = 0; cmd_start = 1;
    while (ndone == 0 && cyc < ROWS + COLS + 12) begin
      @(negedge clk);
      cmd_start = 0;
      if (cyc == inj) begin
        cmd_write = 1; cmd_row = 3'd1; cmd_mask = '1; cmd_data = 8'h00; cmd_start = 1;
      end else cmd_write = 0;
      if (probe_row != '0) begin
        if (pidx >= ROWS || probe_row != ROWS'(1 << pidx)) order_ok = 0;
        pidx++;
      end
      if (drive_en != '0) quiet = 0;
      if (tdo_valid) begin
        if (probe_row != '0) probe_in_shift = 1;
        if (nbits < COLS) sig[nbits] = tdo;
        nbits++;
      end
      if (cmd_done) ndone++;
      cyc++;
    end
    cmd_start = 0; cmd_write = 0;
    chk(order_ok && pidx == ROWS, "R2 probe order", pidx, ROWS);
    chk(nbits == COLS && !probe_in_shift, "R4 serial length", nbits, COLS);
    chk(sig == exp, "R3 signature", sig, exp);
    chk(ndone == 1, "R5 done once", ndone, 1);
    chk(quiet, "R11 no drive during observe", 0, 0);
    if (inj >= 0) chk(quiet && ndone == 1, "R8 start ignored while busy", ndone, 1);
  endtask

  // Write command issued right away; returns in the done cycle.
  task automatic write_cmd(input logic [RW-1:0] row, input logic [COLS-1:0] mask, input logic [COLS-1:0] data);
    logic [ROWS-1:0] expl = (int'(row) < ROWS) ? ROWS'(1 << row) : '0;
    logic [COLS-1:0] expm = (int'(row) < ROWS) ? mask : '0;
    cmd_write = 1; cmd_row = row; cmd_mask = mask; cmd_data = data; cmd_start = 1;
    @(negedge clk);
    cmd_start = 0; cmd_write = 0;
    chk(probe_row == expl, (int'(row) < ROWS) ? "R6 write probe" : "R7 bad row probe", probe_row, expl);
    chk(drive_en == expm && ((drive_val ^ data) & expm) == '0,
        (int'(row) < ROWS) ? "R6 drive mask" : "R7 bad row drive", drive_en, expm);
    @(negedge clk);
    chk(cmd_done == 1 && probe_row == '0 && drive_en == '0, "R5 write done", cmd_done, 1);
  endtask

  task automatic t_reset();
    chk(probe_row == '0 && drive_en == '0 && !tdo_valid && !cmd_done, "R1 reset state",
        {probe_row, drive_en, tdo_valid, cmd_done}, 0);
    repeat (3) @(negedge clk);
    chk(probe_row == '0, "R2 idle no probe", probe_row, 0);
  endtask

  task automatic t_observe_patterns();
    logic [COLS-1:0] s1, s2;
    for (int r = 0; r < ROWS; r++) grid[r] = COLS'(8'h11 * (r + 1));
    @(negedge clk); observe(-1, s1);
    @(negedge clk); observe(-1, s2);
    chk(s1 == s2, "R10 reseeded pass repeats", s2, s1);
    for (int r = 0; r < ROWS; r++) grid[r] = '0;
    @(negedge clk); observe(-1, s1);
    for (int r = 0; r < ROWS; r++) grid[r] = '1;
    @(negedge clk); observe(-1, s1);
  endtask

  task automatic t_write();
    logic [COLS-1:0] s;
    for (int r = 0; r < ROWS; r++) grid[r] = 8'hA5;
    @(negedge clk);
    write_cmd(3'd2, 8'h0F, 8'h3C);
    chk(grid[2] == 8'hAC && grid[1] == 8'hA5, "R6 masked cells forced", grid[2], 8'hAC);
    @(negedge clk);
    write_cmd(3'd5, 8'hF0, 8'h00);
    chk(grid[5] == 8'h05, "R6 force zeros", grid[5], 8'h05);
    @(negedge clk);
    write_cmd(3'd6, 8'hFF, 8'h00);
    write_cmd(3'd7, 8'hFF, 8'h00);
    chk(grid[0] == 8'hA5 && grid[5] == 8'h05, "R7 bad row leaves grid", grid[0], 8'hA5);
    @(negedge clk); observe(-1, s);
  endtask

  task automatic t_busy_start();
    logic [COLS-1:0] s;
    for (int r = 0; r < ROWS; r++) grid[r] = COLS'(8'h37 + 8'h29 * r);
    @(negedge clk); observe(2, s);
    chk(grid[1] == COLS'(8'h37 + 8'h29), "R8 injected write dropped", grid[1], COLS'(8'h60));
  endtask

  task automatic t_back_to_back();
    logic [COLS-1:0] s;
    for (int r = 0; r < ROWS; r++) grid[r] = COLS'(r * 8'h13);
    @(negedge clk); observe(-1, s);
    chk(cmd_done == 1, "R9 in done cycle", cmd_done, 1);
    write_cmd(3'd4, 8'h81, 8'hFF);
    chk(grid[4] == (COLS'(4 * 8'h13) | 8'h81), "R9 back-to-back write", grid[4], COLS'(4 * 8'h13) | 8'h81);
    observe(-1, s);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    rst_n = 0; cmd_start = 0; cmd_write = 0; cmd_row = '0; cmd_mask = '0; cmd_data = '0;
    for (int r = 0; r < ROWS; r++) grid[r] = '0;
    #1;
    chk(probe_row == '0 && tdo_valid == 0 && cmd_done == 0, "R1 in reset", probe_row, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_observe_patterns();
    t_write();
    t_busy_start();
    t_back_to_back();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule